// File: doc/BRIEF.md
# Grouped Error Interrupt Status Collector

This block folds eight level-sensitive device interrupt lines and twenty-three one-cycle error pulses into a single 32-bit status word. Error bits are sticky. Software clears them by functional group, through a write-only group-clear register, and never one bit at a time. On top of the word sit two derived results. One is a multiple-error bit, set when a new error arrives while an older one is still pending. The other is a fatal-error flag computed from a fixed subset of the bits.

A simple 32-bit register bus reaches five word locations: the status word, an enable mask with the same layout, the group-clear register, a line-to-device map, and a per-line mode register. The block drives one interrupt output that is high whenever an enabled status bit is set. It also drives the device number routed to each line and the per-line clear-packet enables.

Top module: `err_irq_collector`

## Requirements
- R1: After reset the status error bits, enable mask, line map and mode register read zero, and irq_out and fatal_out are low.
- R2: Status bits 7:0 hold the value of dev_line sampled at the previous clock edge.
- R3: A pulse on err_evt[k] sets status bit k+8 at the next edge, and the bit stays set until its group is cleared.
- R4: Writing word address 2 clears groups selected by wdata[6:0], taking effect at that edge. Bit 0 clears status bits 8 and 10-15. Bit 1 clears bits 16 and 30. Bit 2 clears bits 17-21. Bit 3 clears bits 23, 24, 25 and 27. Bit 4 clears bits 9, 26 and 28. Bit 5 clears bits 22 and 29. Bit 6 clears bit 31. The value 0x7F clears every error bit.
- R5: Status bit 31 sets at an edge where any err_evt bit is pulsed while any of status bits 8-30 was already set. A pulse with nothing pending leaves bit 31 clear.
- R6: If a bit's error pulse and its group clear occur in the same cycle, the bit ends up set.
- R7: irq_out is high exactly when the status word ANDed with the enable mask (word address 1, read/write) is nonzero.
- R8: fatal_out is high exactly when any of status bits 22-29, 13 or 14 is set.
- R9: Word address 3 holds a 3-bit device number per line, line n at bits 3n+2:3n. It drives line_dev with the same layout and reads back with bits 31:24 as zero.
- R10: Word address 4 bits 7:0 hold one clear-packet enable per line. It drives line_clr_pkt_en and reads back with bits 31:8 as zero.
- R11: bus_rdata shows the selected location in the same cycle. Writes to address 0 are ignored. Address 2 and addresses 5-7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_line | input | 8 | Device interrupt levels |
| err_evt | input | 23 | One-cycle error pulses, bit k maps to status bit k+8 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | 1 | Combined enabled interrupt |
| fatal_out | output | 1 | Fatal error flag |
| line_dev | output | 24 | Device number per line |
| line_clr_pkt_en | output | 8 | Per-line clear-packet enable |

## Verification
The assertions rely on two input assumptions. Error inputs must be true pulses that never need more than one cycle to register. Bus writes are single-cycle strobes whose address and data are valid at the sampling edge. The stimulus changes every input only at the falling edge and lowers err_evt and bus_wr right after the rising edge that consumes them, so each pulse and write counts exactly once. The sweeps cover every error position, every group, every enable bit, all 256 line patterns and each map field. Expected words come from a bench-side model built from the group table.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
    localparam int WORD_W    = 32;
    localparam int LINES     = 8;
    localparam int DEV_W     = 3;
    localparam int ERR_LO    = LINES;
    localparam int MULTI_POS = WORD_W - 1;
    localparam int ERR_N     = MULTI_POS - ERR_LO;
    localparam int MAP_W     = LINES * DEV_W;
    localparam int NUM_GRP   = 7;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_GCLR = 3'd2;
    localparam logic [ADDR_W-1:0] A_MAP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd4;

    localparam logic [WORD_W-1:0] FATAL_MASK = 32'h3FC0_6000;

    typedef struct packed {
        logic             multi;
        logic [ERR_N-1:0] errs;
        logic [LINES-1:0] lines;
    } stat_s;

    typedef struct packed {
        logic [WORD_W-1:0] en;
        logic [MAP_W-1:0]  map;
        logic [LINES-1:0]  mode;
    } cfg_s;

    function automatic logic [WORD_W-1:0] grp_mask(input int g);
        logic [WORD_W-1:0] m;
        case (g)
            0:       m = 32'h0000_FD00;
            1:       m = 32'h4001_0000;
            2:       m = 32'h003E_0000;
            3:       m = 32'h0B80_0000;
            4:       m = 32'h1400_0200;
            5:       m = 32'h2040_0000;
            6:       m = 32'h8000_0000;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] clr_expand(input logic [NUM_GRP-1:0] sel);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (sel[g]) m = m | grp_mask(g);
        end
        return m;
    endfunction
endpackage

// File: rtl/eic_status.sv
`timescale 1ns/1ps
module eic_status
    import eic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   dev_line,
    input  logic [ERR_N-1:0]   err_evt,
    input  logic               clr_stb,
    input  logic [NUM_GRP-1:0] clr_sel,
    output logic [WORD_W-1:0]  status_o
);
    stat_s             stat_d, stat_q;
    logic [WORD_W-1:0] clr_w;

    always_comb begin
        clr_w        = clr_stb ? clr_expand(clr_sel) : '0;
        stat_d       = stat_q;
        stat_d.lines = dev_line;
        stat_d.errs  = (stat_q.errs & ~clr_w[MULTI_POS-1:ERR_LO]) | err_evt;
        stat_d.multi = (stat_q.multi & ~clr_w[MULTI_POS])
                     | ((|err_evt) & (|stat_q.errs));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status_o = stat_q;

    // R3
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o[MULTI_POS-1:ERR_LO] & $past(err_evt)) == $past(err_evt)));

    // R4
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status_o[MULTI_POS-1:ERR_LO]) & ~$past(clr_w[MULTI_POS-1:ERR_LO]))
          & ~status_o[MULTI_POS-1:ERR_LO]) == '0));

    // R5
    multi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[MULTI_POS]) |-> ($past(|err_evt) && $past(|status_o[MULTI_POS-1:ERR_LO])));
endmodule

// File: rtl/eic_cfg.sv
`timescale 1ns/1ps
module eic_cfg
    import eic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  en_o,
    output logic [MAP_W-1:0]   map_o,
    output logic [LINES-1:0]   mode_o,
    output logic               clr_stb_o,
    output logic [NUM_GRP-1:0] clr_sel_o
);
    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) begin
            case (bus_addr)
                A_EN:    cfg_d.en   = bus_wdata;
                A_MAP:   cfg_d.map  = bus_wdata[MAP_W-1:0];
                A_MODE:  cfg_d.mode = bus_wdata[LINES-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o      = cfg_q.en;
    assign map_o     = cfg_q.map;
    assign mode_o    = cfg_q.mode;
    assign clr_stb_o = bus_wr && (bus_addr == A_GCLR);
    assign clr_sel_o = bus_wdata[NUM_GRP-1:0];

    // R9
    map_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MAP) |=> (map_o == $past(bus_wdata[MAP_W-1:0])));

    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_EN) |=> $stable(en_o));
endmodule

// File: rtl/eic_out.sv
`timescale 1ns/1ps
module eic_out
    import eic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] status_i,
    input  logic [WORD_W-1:0] en_i,
    input  logic [MAP_W-1:0]  map_i,
    input  logic [LINES-1:0]  mode_i,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              irq_o,
    output logic              fatal_o,
    output logic [WORD_W-1:0] rdata_o
);
    always_comb begin
        irq_o   = |(status_i & en_i);
        fatal_o = |(status_i & FATAL_MASK);
        case (bus_addr)
            A_STAT:  rdata_o = status_i;
            A_EN:    rdata_o = en_i;
            A_MAP:   rdata_o = {{(WORD_W-MAP_W){1'b0}}, map_i};
            A_MODE:  rdata_o = {{(WORD_W-LINES){1'b0}}, mode_i};
            default: rdata_o = '0;
        endcase
    end

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/err_irq_collector.sv
`timescale 1ns/1ps
module err_irq_collector
    import eic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  dev_line,
    input  logic [ERR_N-1:0]  err_evt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              fatal_out,
    output logic [MAP_W-1:0]  line_dev,
    output logic [LINES-1:0]  line_clr_pkt_en
);
    logic [WORD_W-1:0]  status_w;
    logic [WORD_W-1:0]  en_w;
    logic [MAP_W-1:0]   map_w;
    logic [LINES-1:0]   mode_w;
    logic               clr_stb_w;
    logic [NUM_GRP-1:0] clr_sel_w;

    eic_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_o      (en_w),
        .map_o     (map_w),
        .mode_o    (mode_w),
        .clr_stb_o (clr_stb_w),
        .clr_sel_o (clr_sel_w)
    );

    eic_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_line (dev_line),
        .err_evt  (err_evt),
        .clr_stb  (clr_stb_w),
        .clr_sel  (clr_sel_w),
        .status_o (status_w)
    );

    eic_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_w),
        .en_i     (en_w),
        .map_i    (map_w),
        .mode_i   (mode_w),
        .bus_addr (bus_addr),
        .irq_o    (irq_out),
        .fatal_o  (fatal_out),
        .rdata_o  (bus_rdata)
    );

    assign line_dev        = map_w;
    assign line_clr_pkt_en = mode_w;

    // R8
    all_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_GCLR && bus_wdata[NUM_GRP-1:0] == '1 && err_evt == '0)
        |=> (!fatal_out && !bus_rdata[MULTI_POS] || bus_addr != A_STAT) && !fatal_out);
endmodule

// File: tb/err_irq_collector_bench.sv
`timescale 1ns/1ps
module err_irq_collector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dev_line = '0;
    logic [22:0] err_evt = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, fatal_out;
    logic [23:0] line_dev;
    logic [7:0]  line_clr_pkt_en;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    logic [31:0] model = '0;
    logic [31:0] en_m = '0;
    logic [31:0] rd_v;

    always #2.5 clk = ~clk;

    err_irq_collector u_err_irq_collector (
        .clk(clk), .rst_n(rst_n), .dev_line(dev_line), .err_evt(err_evt),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out), .fatal_out(fatal_out),
        .line_dev(line_dev), .line_clr_pkt_en(line_clr_pkt_en)
    );

    function automatic logic [31:0] gmask(input int g);
        logic [31:0] m = '0;
        case (g)
            0: begin m[8] = 1'b1; for (int b = 10; b <= 15; b++) m[b] = 1'b1; end
            1: begin m[16] = 1'b1; m[30] = 1'b1; end
            2: for (int b = 17; b <= 21; b++) m[b] = 1'b1;
            3: begin m[23] = 1'b1; m[24] = 1'b1; m[25] = 1'b1; m[27] = 1'b1; end
            4: begin m[9] = 1'b1; m[26] = 1'b1; m[28] = 1'b1; end
            5: begin m[22] = 1'b1; m[29] = 1'b1; end
            6: m[31] = 1'b1;
            default: ;
        endcase
        return m;
    endfunction

    function automatic logic is_fatal(input logic [31:0] s);
        logic f = 1'b0;
        for (int b = 22; b <= 29; b++) f = f | s[b];
        return f | s[13] | s[14];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [22:0] evt, input logic wr,
                        input logic [2:0] a, input logic [31:0] d);
        logic [31:0] cm;
        logic [31:0] nx;
        @(negedge clk);
        err_evt = evt; bus_wr = wr; bus_addr = a; bus_wdata = d;
        cm = '0;
        if (wr && a == 3'd2)
            for (int g = 0; g < 7; g++) if (d[g]) cm = cm | gmask(g);
        nx[7:0]   = dev_line;
        nx[30:8]  = (model[30:8] & ~cm[30:8]) | evt;
        nx[31]    = (model[31] & ~cm[31]) | ((|evt) & (|model[30:8]));
        model = nx;
        if (wr && a == 3'd1) en_m = d;
        @(posedge clk);
        #1;
        err_evt = '0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        rd(3'd0, rd_v); chk("R1 status", rd_v, 32'h0);
        rd(3'd1, rd_v); chk("R1 enable", rd_v, 32'h0);
        rd(3'd3, rd_v); chk("R1 map", rd_v, 32'h0);
        rd(3'd4, rd_v); chk("R1 mode", rd_v, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
        chk("R1 fatal", {31'b0, fatal_out}, 32'h0);

        // R2 and R7: sweep all line patterns with lines enabled
        step('0, 1'b1, 3'd1, 32'h0000_00FF);
        for (int v = 0; v < 256; v++) begin
            dev_line = v[7:0];
            step('0, 1'b0, 3'd0, '0);
            rd(3'd0, rd_v); chk("R2 lines", rd_v, model);
            chk("R7 irq lines", {31'b0, irq_out}, {31'b0, |(model & en_m)});
        end
        dev_line = '0;
        step('0, 1'b1, 3'd1, 32'hFFFF_FFFF);

        // R3 / R8: each error source alone
        for (int k = 0; k < 23; k++) begin
            step(23'(1) << k, 1'b0, 3'd0, '0);
            rd(3'd0, rd_v); chk("R3 set", rd_v, 32'(1) << (k + 8));
            step('0, 1'b0, 3'd0, '0);
            rd(3'd0, rd_v); chk("R3 sticky", rd_v, model);
            chk("R8 fatal", {31'b0, fatal_out}, {31'b0, is_fatal(model)});
            chk("R7 irq err", {31'b0, irq_out}, 32'h1);
            step('0, 1'b1, 3'd2, 32'h7F);
            rd(3'd0, rd_v); chk("R4 clear all", rd_v, 32'h0);
            chk("R8 fatal cleared", {31'b0, fatal_out}, 32'h0);
        end

        // R5 multiple-error bit
        step(23'h1, 1'b0, 3'd0, '0);
        rd(3'd0, rd_v); chk("R5 first pulse", {31'b0, rd_v[31]}, 32'h0);
        step(23'h2, 1'b0, 3'd0, '0);
        rd(3'd0, rd_v); chk("R5 second pulse", {31'b0, rd_v[31]}, 32'h1);
        chk("R5 word", rd_v, model);
        step('0, 1'b1, 3'd2, 32'h7F);

        // R4 each group alone from a full word
        for (int g = 0; g < 7; g++) begin
            step(23'h7FFFFF, 1'b0, 3'd0, '0);
            step(23'h7FFFFF, 1'b0, 3'd0, '0);
            step('0, 1'b1, 3'd2, 32'(1) << g);
            rd(3'd0, rd_v);
            chk("R4 group", rd_v, 32'hFFFF_FF00 & ~gmask(g));
            rd(3'd2, rd_v); chk("R11 clear reads zero", rd_v, 32'h0);
            step('0, 1'b1, 3'd2, 32'h7F);
        end

        // R6 set wins over clear in the same cycle
        step(23'(1) << 15, 1'b1, 3'd2, 32'h08);
        rd(3'd0, rd_v); chk("R6 set wins", rd_v, 32'h0080_0000);
        step('0, 1'b1, 3'd2, 32'h08);
        rd(3'd0, rd_v); chk("R6 later clear", rd_v, 32'h0);

        // R7 single enable bit sweep over a fixed pattern
        dev_line = 8'hA5;
        step(23'h155555, 1'b0, 3'd0, '0);
        for (int b = 0; b < 32; b++) begin
            step('0, 1'b1, 3'd1, 32'(1) << b);
            chk("R7 single enable", {31'b0, irq_out}, {31'b0, model[b]});
        end
        step('0, 1'b1, 3'd1, 32'h0);
        chk("R7 no enable", {31'b0, irq_out}, 32'h0);

        // R11 writes to status ignored; unused addresses read zero
        step('0, 1'b1, 3'd0, 32'hFFFF_FFFF);
        rd(3'd0, rd_v); chk("R11 status write ignored", rd_v, model);
        for (int a = 5; a < 8; a++) begin
            rd(a[2:0], rd_v); chk("R11 unused address", rd_v, 32'h0);
        end
        dev_line = '0;
        step('0, 1'b1, 3'd2, 32'h7F);

        // R9 line map fields
        for (int n = 0; n < 8; n++) begin
            for (int d = 0; d < 8; d++) begin
                step('0, 1'b1, 3'd3, 32'(d) << (3 * n));
                chk("R9 line_dev", {8'b0, line_dev}, 32'(d) << (3 * n));
                chk("R9 field", {29'b0, line_dev[3*n +: 3]}, 32'(d));
            end
        end
        step('0, 1'b1, 3'd3, 32'hFFFF_FFFF);
        rd(3'd3, rd_v); chk("R9 readback", rd_v, 32'h00FF_FFFF);

        // R10 mode register
        for (int m = 0; m < 256; m += 17) begin
            step('0, 1'b1, 3'd4, 32'hFFFF_FF00 | 32'(m));
            chk("R10 output", {24'b0, line_clr_pkt_en}, 32'(m));
            rd(3'd4, rd_v); chk("R10 readback", rd_v, 32'(m));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule